// File: doc/BRIEF.md
# Chip-Select Gated Command Register

This block is a one-stage clocked register for the address and command lanes of a memory command path. The data lanes update only when the bus is addressed to this register. That is the case when at least one of two active-low chip selects is low. When both selects are high, the data lanes keep their previous contents. Two control lanes, clock-enable and termination-enable, are captured on every edge whatever the selects do. A copy of the primary chip select is also registered on every edge into its own lane.

Two configuration straps are sampled while reset is held. The first strap picks one of two layouts. In the wide layout, 25 lanes are registered one-to-one. In the split layout, 14 lanes are registered and each one drives an A copy and a B copy. The second strap picks where the two control lanes sit in the split layout. Tying the secondary select low turns the gating off, so every edge captures all lanes.

Top module: `csgated_cmd_reg`

## Requirements
- R1: When `cs_pri_n` and `cs_sec_n` are both 1 at a rising edge, every gated data lane keeps its previous value. The gated lanes are all active lanes except the two control lanes and lane 6.
- R2: When `cs_pri_n` or `cs_sec_n` is 0 at a rising edge, every gated data lane takes the value of `d_bus` at that lane. The new value is visible on the outputs after that edge.
- R3: The control lanes are captured on every edge regardless of the selects. In the wide layout and in split variant A, clock-enable is lane 0 and termination-enable is lane 3. In split variant B, clock-enable is lane 13 and termination-enable is lane 10.
- R4: Output lane 6 carries the value that `cs_pri_n` had at the previous edge and is never held by the gating. The value on `d_bus[6]` is ignored.
- R5: `rst` is synchronous and active high and takes priority over the selects. After an edge with `rst` at 1, `q_a` and `q_b` are all zero.
- R6: With `cfg_split` latched at 0, all 25 lanes appear on `q_a[24:0]`, `q_b` is zero, and `cfg_variant` has no effect.
- R7: With `cfg_split` latched at 1, only lanes 13..0 are registered. `q_b` equals `q_a[13:0]`, `q_a[24:14]` is zero, and `d_bus[24:14]` is ignored.
- R8: With `cs_sec_n` held at 0, every edge captures all data lanes, whatever the level of `cs_pri_n`.
- R9: `cfg_split` and `cfg_variant` are latched only on edges with `rst` at 1. Changes while out of reset have no effect until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset, also latches the straps |
| cfg_split | input | 1 | Strap: 0 = 25-lane one-to-one, 1 = 14-lane split with A and B copies |
| cfg_variant | input | 1 | Strap: split-layout control-lane placement, 0 = variant A, 1 = variant B |
| cs_pri_n | input | 1 | Primary chip select, active low; also registered to lane 6 |
| cs_sec_n | input | 1 | Secondary chip select, active low |
| d_bus | input | 25 | Command and address lanes, index = lane number |
| q_a | output | 25 | Registered lanes, A copy |
| q_b | output | 14 | Registered lanes, B copy in the split layout, zero otherwise |

## Verification
Two things can happen in the same edge. Some lanes must hold because both selects are high, while the control lanes and lane 6 must still take new values. The bench provokes this by driving a `d_bus` pattern that differs from the stored word in every lane while both selects are high. It then checks lane by lane that only the two control positions of the current layout and the select copy changed. A second overlap puts reset in the same edge as an active select carrying all-ones data; the bench judges it by requiring an all-zero output after that edge.

// File: rtl/cmdreg_pkg.sv
package cmdreg_pkg;

  // Default geometry of the command register
  localparam int unsigned WIDE_LANES_DEF   = 25;
  localparam int unsigned NARROW_LANES_DEF = 14;

  // Lane positions that the layout rules depend on
  localparam int unsigned CS_LANE_DEF      = 6;
  localparam int unsigned CKE_LANE_A_DEF   = 0;
  localparam int unsigned ODT_LANE_A_DEF   = 3;
  localparam int unsigned CKE_LANE_B_DEF   = 13;
  localparam int unsigned ODT_LANE_B_DEF   = 10;

  // Configuration straps, latched while reset is held
  typedef struct packed {
    logic split;    // 0: one-to-one, 1: split with A and B copies
    logic variant;  // split layout control placement: 0 = A, 1 = B
  } strap_t;

endpackage

// File: rtl/cmdreg_lane_map.sv
module cmdreg_lane_map #(
  parameter int unsigned WIDE_LANES   = cmdreg_pkg::WIDE_LANES_DEF,
  parameter int unsigned NARROW_LANES = cmdreg_pkg::NARROW_LANES_DEF,
  parameter int unsigned CS_LANE      = cmdreg_pkg::CS_LANE_DEF,
  parameter int unsigned CKE_LANE_A   = cmdreg_pkg::CKE_LANE_A_DEF,
  parameter int unsigned ODT_LANE_A   = cmdreg_pkg::ODT_LANE_A_DEF,
  parameter int unsigned CKE_LANE_B   = cmdreg_pkg::CKE_LANE_B_DEF,
  parameter int unsigned ODT_LANE_B   = cmdreg_pkg::ODT_LANE_B_DEF
) (
  input  cmdreg_pkg::strap_t    straps,
  output logic [WIDE_LANES-1:0] live_mask,  // lanes registered at all
  output logic [WIDE_LANES-1:0] free_mask,  // control lanes, never gated
  output logic [WIDE_LANES-1:0] cs_mask     // lane carrying the select copy
);

  logic use_b_layout;
  assign use_b_layout = straps.split & straps.variant;

  for (genvar i = 0; i < WIDE_LANES; i++) begin : g_lane
    localparam bit IN_NARROW = (i < NARROW_LANES);
    localparam bit IS_CS     = (i == CS_LANE);
    localparam bit IS_CTRL_A = (i == CKE_LANE_A) || (i == ODT_LANE_A);
    localparam bit IS_CTRL_B = (i == CKE_LANE_B) || (i == ODT_LANE_B);

    assign live_mask[i] = IN_NARROW ? 1'b1 : ~straps.split;
    assign cs_mask[i]   = IS_CS;
    assign free_mask[i] = use_b_layout ? IS_CTRL_B : IS_CTRL_A;
  end

endmodule

// File: rtl/cmdreg_core.sv
module cmdreg_core #(
  parameter int unsigned WIDE_LANES = cmdreg_pkg::WIDE_LANES_DEF,
  parameter int unsigned CS_LANE    = cmdreg_pkg::CS_LANE_DEF
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cs_pri_n,
  input  logic                  cs_sec_n,
  input  logic [WIDE_LANES-1:0] d_bus,
  input  logic [WIDE_LANES-1:0] live_mask,
  input  logic [WIDE_LANES-1:0] free_mask,
  input  logic [WIDE_LANES-1:0] cs_mask,
  output logic [WIDE_LANES-1:0] lanes_q
);

  logic                  gate_open;
  logic [WIDE_LANES-1:0] lanes_d;
  logic [WIDE_LANES-1:0] gated_mask;

  // Either active-low select opens the data lanes
  assign gate_open  = ~cs_pri_n | ~cs_sec_n;
  assign gated_mask = live_mask & ~free_mask & ~cs_mask;

  for (genvar i = 0; i < WIDE_LANES; i++) begin : g_next
    always_comb begin
      if (!live_mask[i])                lanes_d[i] = 1'b0;
      else if (cs_mask[i])              lanes_d[i] = cs_pri_n;
      else if (free_mask[i] | gate_open) lanes_d[i] = d_bus[i];
      else                              lanes_d[i] = lanes_q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) lanes_q <= '0;
    else     lanes_q <= lanes_d;
  end

  AST_HOLD_WHEN_DESELECTED: assert property (@(posedge clk) disable iff (rst)
    (cs_pri_n && cs_sec_n) |=> ((lanes_q ^ $past(lanes_q)) & gated_mask) == '0) // R1
    else $error("gated lanes changed while deselected");

  AST_CAPTURE_WHEN_SELECTED: assert property (@(posedge clk) disable iff (rst)
    (!cs_pri_n || !cs_sec_n) |=> (lanes_q & gated_mask) == ($past(d_bus) & gated_mask)) // R2
    else $error("gated lanes missed a selected capture");

  AST_CTRL_UNGATED: assert property (@(posedge clk) disable iff (rst)
    (cs_pri_n && cs_sec_n) |=> (lanes_q & free_mask) == ($past(d_bus) & free_mask)) // R3
    else $error("control lanes were held by the gating");

  AST_CS_COPY: assert property (@(posedge clk) disable iff (rst)
    (!cs_pri_n || cs_pri_n) |=> lanes_q[CS_LANE] == $past(cs_pri_n)) // R4
    else $error("select copy lane wrong");

endmodule

// File: rtl/cmdreg_fanout.sv
module cmdreg_fanout #(
  parameter int unsigned WIDE_LANES   = cmdreg_pkg::WIDE_LANES_DEF,
  parameter int unsigned NARROW_LANES = cmdreg_pkg::NARROW_LANES_DEF
) (
  input  logic                    split,
  input  logic [WIDE_LANES-1:0]   lanes_q,
  output logic [WIDE_LANES-1:0]   q_a,
  output logic [NARROW_LANES-1:0] q_b
);

  localparam int unsigned UPPER_LANES = WIDE_LANES - NARROW_LANES;

  // Upper lanes are already cleared in the register when split
  assign q_a = split ? {{UPPER_LANES{1'b0}}, lanes_q[NARROW_LANES-1:0]} : lanes_q;
  assign q_b = split ? lanes_q[NARROW_LANES-1:0] : '0;

endmodule

// File: rtl/csgated_cmd_reg.sv
module csgated_cmd_reg #(
  parameter int unsigned WIDE_LANES   = cmdreg_pkg::WIDE_LANES_DEF,
  parameter int unsigned NARROW_LANES = cmdreg_pkg::NARROW_LANES_DEF
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cfg_split,
  input  logic                    cfg_variant,
  input  logic                    cs_pri_n,
  input  logic                    cs_sec_n,
  input  logic [WIDE_LANES-1:0]   d_bus,
  output logic [WIDE_LANES-1:0]   q_a,
  output logic [NARROW_LANES-1:0] q_b
);

  cmdreg_pkg::strap_t    straps_q;
  logic [WIDE_LANES-1:0] live_mask;
  logic [WIDE_LANES-1:0] free_mask;
  logic [WIDE_LANES-1:0] cs_mask;
  logic [WIDE_LANES-1:0] lanes_q;

  // Straps are only sampled while reset is held
  always_ff @(posedge clk) begin
    if (rst) begin
      straps_q.split   <= cfg_split;
      straps_q.variant <= cfg_variant;
    end
  end

  cmdreg_lane_map #(
    .WIDE_LANES  (WIDE_LANES),
    .NARROW_LANES(NARROW_LANES)
  ) i_lane_map (
    .straps   (straps_q),
    .live_mask(live_mask),
    .free_mask(free_mask),
    .cs_mask  (cs_mask)
  );

  cmdreg_core #(
    .WIDE_LANES(WIDE_LANES)
  ) i_core (
    .clk      (clk),
    .rst      (rst),
    .cs_pri_n (cs_pri_n),
    .cs_sec_n (cs_sec_n),
    .d_bus    (d_bus),
    .live_mask(live_mask),
    .free_mask(free_mask),
    .cs_mask  (cs_mask),
    .lanes_q  (lanes_q)
  );

  cmdreg_fanout #(
    .WIDE_LANES  (WIDE_LANES),
    .NARROW_LANES(NARROW_LANES)
  ) i_fanout (
    .split  (straps_q.split),
    .lanes_q(lanes_q),
    .q_a    (q_a),
    .q_b    (q_b)
  );

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (q_a == '0 && q_b == '0)) // R5
    else $error("outputs not cleared by reset");

  AST_WIDE_NO_B_COPY: assert property (@(posedge clk) disable iff (rst)
    !straps_q.split |=> q_b == '0) // R6
    else $error("B copy active in one-to-one layout");

  AST_SPLIT_COPIES: assert property (@(posedge clk) disable iff (rst)
    straps_q.split |=> (q_b == q_a[NARROW_LANES-1:0]) &&
                       (q_a[WIDE_LANES-1:NARROW_LANES] == '0)) // R7
    else $error("split copies disagree");

  AST_TIED_SECONDARY: assert property (@(posedge clk) disable iff (rst)
    (!cs_sec_n && !straps_q.split) |=>
      (q_a & ~free_mask & ~cs_mask) == ($past(d_bus) & ~free_mask & ~cs_mask)) // R8
    else $error("tied secondary select did not disable gating");

endmodule

// File: tb/test_csgated_cmd_reg.sv
module test_csgated_cmd_reg;

  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_split, cfg_variant;
  logic        cs_pri_n, cs_sec_n;
  logic [24:0] d_bus;
  logic [24:0] q_a;
  logic [13:0] q_b;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  localparam logic [24:0] MASK_A = 25'h0000009;  // lanes 0 and 3
  localparam logic [24:0] MASK_B = 25'h0002400;  // lanes 13 and 10

  always #5 clk = ~clk;

  csgated_cmd_reg i_csgated_cmd_reg (
    .clk(clk), .rst(rst), .cfg_split(cfg_split), .cfg_variant(cfg_variant),
    .cs_pri_n(cs_pri_n), .cs_sec_n(cs_sec_n), .d_bus(d_bus),
    .q_a(q_a), .q_b(q_b)
  );

  function automatic logic [24:0] with_cs(logic [24:0] v, logic cs);
    v[6] = cs;
    return v;
  endfunction

  function automatic logic [24:0] narrow(logic [24:0] v);
    return {11'b0, v[13:0]};
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(string tag, logic [24:0] ea, logic [13:0] eb);
    n_tests++;
    if (q_a !== ea || q_b !== eb) begin
      n_fail++;
      $display("FAIL %s: q_a=%h q_b=%h expected q_a=%h q_b=%h", tag, q_a, q_b, ea, eb);
    end
  endtask

  task automatic do_reset(logic split, logic variant);
    rst = 1'b1; cfg_split = split; cfg_variant = variant;
    cs_pri_n = 1'b1; cs_sec_n = 1'b1; d_bus = '0;
    tick(); tick();
    check("R5 reset state", '0, '0);
    rst = 1'b0;
  endtask

  task automatic t_wide_capture();
    logic [24:0] e;
    cs_pri_n = 1'b0; cs_sec_n = 1'b1; d_bus = 25'h15A3C97;
    tick(); e = with_cs(25'h15A3C97, 1'b0);
    check("R2 R4 R6 wide capture via primary", e, '0);
    d_bus = 25'h0A5C368;
    tick(); e = with_cs(25'h0A5C368, 1'b0);
    check("R2 R6 wide capture second pattern", e, '0);
  endtask

  task automatic t_wide_hold();
    logic [24:0] prev, e;
    prev = with_cs(25'h0A5C368, 1'b0);
    cs_pri_n = 1'b1; cs_sec_n = 1'b1; d_bus = ~25'h0A5C368;
    tick(); e = with_cs((prev & ~MASK_A) | (~25'h0A5C368 & MASK_A), 1'b1);
    check("R1 R3 R4 hold with control update", e, '0);
    prev = e; d_bus = 25'h1FFFFFF;
    tick(); e = with_cs((prev & ~MASK_A) | MASK_A, 1'b1);
    check("R1 R3 second held edge", e, '0);
  endtask

  task automatic t_secondary_tied();
    cs_pri_n = 1'b1; cs_sec_n = 1'b0; d_bus = 25'h1234567;
    tick();
    check("R2 R8 capture via secondary", with_cs(25'h1234567, 1'b1), '0);
    cs_pri_n = 1'b0; d_bus = 25'h0000000;
    tick();
    check("R8 tied secondary, zeros", with_cs(25'h0, 1'b0), '0);
    cs_pri_n = 1'b1; d_bus = 25'h1FFFFBF;
    tick();
    check("R8 tied secondary, ones", 25'h1FFFFFF, '0);
  endtask

  task automatic t_variant_in_wide();
    logic [24:0] prev, e;
    do_reset(1'b0, 1'b1);
    cs_pri_n = 1'b0; cs_sec_n = 1'b1; d_bus = 25'h0000000;
    tick();
    check("R6 variant strap, wide capture", '0, '0);
    prev = '0; cs_pri_n = 1'b1; d_bus = 25'h1FFFFFF;
    tick(); e = with_cs((prev & ~MASK_A) | MASK_A, 1'b1);
    check("R6 R3 variant ignored in wide hold", e, '0);
  endtask

  task automatic t_split_a();
    logic [24:0] prev, e;
    do_reset(1'b1, 1'b0);
    cs_pri_n = 1'b0; cs_sec_n = 1'b1; d_bus = 25'h1FFFFFF;
    tick(); e = narrow(with_cs(25'h1FFFFFF, 1'b0));
    check("R7 split A capture", e, e[13:0]);
    prev = e; cs_pri_n = 1'b1; d_bus = 25'h0000000;
    tick(); e = narrow(with_cs(prev & ~MASK_A, 1'b1));
    check("R3 R7 split A hold", e, e[13:0]);
  endtask

  task automatic t_split_b();
    logic [24:0] prev, e;
    do_reset(1'b1, 1'b1);
    cs_pri_n = 1'b0; cs_sec_n = 1'b1; d_bus = 25'h15A3C97;
    tick(); e = narrow(with_cs(25'h15A3C97, 1'b0));
    check("R7 split B capture", e, e[13:0]);
    prev = e; cs_pri_n = 1'b1; d_bus = ~25'h15A3C97;
    tick(); e = narrow(with_cs((prev & ~MASK_B) | (~25'h15A3C97 & MASK_B), 1'b1));
    check("R3 split B hold", e, e[13:0]);
  endtask

  task automatic t_reset_priority();
    rst = 1'b1; cs_pri_n = 1'b0; cs_sec_n = 1'b0; d_bus = 25'h1FFFFFF;
    tick();
    check("R5 reset beats active selects", '0, '0);
    rst = 1'b0;
  endtask

  task automatic t_strap_latch();
    logic [24:0] prev, e;
    cfg_split = 1'b0; cfg_variant = 1'b0;
    cs_pri_n = 1'b0; cs_sec_n = 1'b1; d_bus = 25'h1FFFFFF;
    tick(); e = narrow(with_cs(25'h1FFFFFF, 1'b0));
    check("R9 strap change out of reset ignored", e, e[13:0]);
    prev = e; cs_pri_n = 1'b1; d_bus = '0;
    tick(); e = narrow(with_cs(prev & ~MASK_B, 1'b1));
    check("R9 latched variant B still in force", e, e[13:0]);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; cfg_split = 1'b0; cfg_variant = 1'b0;
    cs_pri_n = 1'b1; cs_sec_n = 1'b1; d_bus = '0;
    do_reset(1'b0, 1'b0);
    t_wide_capture();
    t_wide_hold();
    t_secondary_tied();
    t_variant_in_wide();
    t_split_a();
    t_split_b();
    t_reset_priority();
    t_strap_latch();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule